// File: doc/BRIEF.md
# Follower JTAG Test Logic Unit

This block adds chip-specific test registers to a JTAG port whose only TAP controller and instruction register belong to an embedded core. The block has no TAP state machine of its own and never sees TMS. It receives TCK, TRST_N and TDI alongside the core. It also receives the core's TAP state as a 4-bit code and the instruction currently held in the core's instruction register.

From the instruction, the block decides whether the operation belongs to the core or to itself. A small, parameterised set of opcodes is claimed locally. Three of them each place one local data register between TDI and TDO: a boundary scan register, a test register and a key/fuse register. The fourth, HIGH_Z, forces all pin output-enables inactive and places a one-bit bypass stage in the chain. Every other opcode is left to the core, and TDO then passes the core's serial output through.

The boundary scan register is always reachable. The test and key/fuse registers are reachable only while a restricted-access enable is high. When that enable is low, their opcodes are handed back to the core.

Top module: `jtag_test_follower`

## Requirements
- R1: An opcode outside the claimed set (boundary scan, HIGH_Z, and test or key/fuse while enabled) leaves the block idle, and `tdo` equals `core_tdo` in every TAP state.
- R2: On a rising TCK edge in Capture-DR (state code 4'h6), the shift stage of the selected local register loads its parallel capture input.
- R3: On each rising TCK edge in Shift-DR (state code 4'h2), the selected shift stage moves one place toward bit 0, and `tdi` enters the most significant bit. Bit 0 is the bit presented to `tdo`.
- R4: While a claimed opcode is active in Shift-DR, `tdo` shows the local serial bit, and it changes only on falling TCK edges. A rising edge leaves `tdo` unchanged.
- R5: On a rising TCK edge in Update-DR (state code 4'h5), the selected register's update output takes the value of its shift stage. In every other state the update outputs hold, including during shifting.
- R6: While `priv_en` is low, the test and key/fuse opcodes are treated as core-owned: `tdo` follows `core_tdo`, and neither register changes.
- R7: The HIGH_Z opcode drives `pins_hiz` high from the first rising edge at which it is present. It selects a one-bit bypass stage that captures 0 and shifts `tdi` through with one stage of delay.
- R8: A low `trst_n` clears all shift stages, update outputs, the bypass stage and `pins_hiz` at once, without a clock, and returns `tdo` to `core_tdo`.
- R9: Capture, shift and update leave the registers that are not selected unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock shared with the core |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| tap_state | input | 4 | Core TAP state, standard 1149.1 encoding |
| ir_code | input | IR_W | Instruction held by the core's instruction register |
| priv_en | input | 1 | Restricted-access enable for the test and key/fuse registers |
| core_tdo | input | 1 | Serial output of the core |
| bsr_cap | input | BSR_LEN | Parallel capture value for the boundary scan register |
| tst_cap | input | TST_LEN | Parallel capture value for the test register |
| key_cap | input | KEY_LEN | Parallel capture value for the key/fuse register |
| tdo | output | 1 | Serial test data out |
| pins_hiz | output | 1 | High forces all pin output-enables inactive |
| bsr_upd | output | BSR_LEN | Boundary scan update outputs |
| tst_upd | output | TST_LEN | Test register update outputs |
| key_upd | output | KEY_LEN | Key/fuse register update outputs |

## Verification
The assertions assume that `tap_state` only walks legal TAP sequences and changes just after a rising TCK edge, as a real TAP controller's outputs do. They also assume that `ir_code` and `priv_en` change only at those same points. The stimulus drives every input one time unit after a rising edge. It changes capture values only while the TAP sits in Run-Test/Idle, so no register ever samples an input during its transition. The stimulus moves through Capture, Shift, Pause, Exit and Update sequences, as a core TAP would.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  typedef enum logic [3:0] {
    ST_EXIT2_DR   = 4'h0,
    ST_EXIT1_DR   = 4'h1,
    ST_SHIFT_DR   = 4'h2,
    ST_PAUSE_DR   = 4'h3,
    ST_SELECT_IR  = 4'h4,
    ST_UPDATE_DR  = 4'h5,
    ST_CAPTURE_DR = 4'h6,
    ST_SELECT_DR  = 4'h7,
    ST_EXIT2_IR   = 4'h8,
    ST_EXIT1_IR   = 4'h9,
    ST_SHIFT_IR   = 4'hA,
    ST_PAUSE_IR   = 4'hB,
    ST_RUN_IDLE   = 4'hC,
    ST_UPDATE_IR  = 4'hD,
    ST_CAPTURE_IR = 4'hE,
    ST_RESET      = 4'hF
  } tap_st_e;

  typedef enum logic [2:0] {
    PATH_CORE = 3'd0,
    PATH_BSR  = 3'd1,
    PATH_TST  = 3'd2,
    PATH_KEY  = 3'd3,
    PATH_BYP  = 3'd4
  } path_e;

endpackage

// File: rtl/jtu_decode.sv
module jtu_decode
  import jtu_pkg::*;
#(
  parameter int              IR_W     = 5,
  parameter logic [IR_W-1:0] OP_BSR   = 5'h01,
  parameter logic [IR_W-1:0] OP_TST   = 5'h1C,
  parameter logic [IR_W-1:0] OP_KEY   = 5'h1A,
  parameter logic [IR_W-1:0] OP_HIGHZ = 5'h08
) (
  input  logic [IR_W-1:0] ir_code,
  input  logic            priv_en,
  output path_e           path
);

  always_comb begin
    path = PATH_CORE;
    if (ir_code == OP_BSR)                   path = PATH_BSR;
    else if (ir_code == OP_HIGHZ)            path = PATH_BYP;
    else if (priv_en && ir_code == OP_TST)   path = PATH_TST;
    else if (priv_en && ir_code == OP_KEY)   path = PATH_KEY;
  end

endmodule

// File: rtl/jtu_dreg.sv
module jtu_dreg #(
  parameter int LEN = 8
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           sel,
  input  logic           cap_en,
  input  logic           shf_en,
  input  logic           upd_en,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_val,
  output logic           sr_lsb,
  output logic [LEN-1:0] upd_q
);

  logic [LEN-1:0] sr;
  logic [LEN-1:0] sr_shifted;

  generate
    if (LEN == 1) begin : g_one
      assign sr_shifted = tdi;
    end else begin : g_multi
      assign sr_shifted = {tdi, sr[LEN-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0;
    end else if (sel) begin
      if (cap_en)      sr <= cap_val;
      else if (shf_en) sr <= sr_shifted;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             upd_q <= '0;
    else if (sel && upd_en)  upd_q <= sr;
  end

  assign sr_lsb = sr[0];

  // R2
  capture_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && cap_en) |=> (sr == $past(cap_val)));

  // R3
  shift_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && shf_en && !cap_en) |=> (sr[LEN-1] == $past(tdi)));

  // R5
  update_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!$past(sel && upd_en)) |-> $stable(upd_q));

endmodule

// File: rtl/jtu_tdo_out.sv
module jtu_tdo_out (
  input  logic tck,
  input  logic trst_n,
  input  logic shift_own,
  input  logic local_bit,
  input  logic core_tdo,
  output logic tdo
);

  logic own_q;
  logic bit_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      own_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      own_q <= shift_own;
      bit_q <= local_bit;
    end
  end

  assign tdo = own_q ? bit_q : core_tdo;

  // R4
  local_tdo_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
    own_q |-> (tdo == bit_q));

endmodule

// File: rtl/jtag_test_follower.sv
module jtag_test_follower
  import jtu_pkg::*;
#(
  parameter int              IR_W     = 5,
  parameter int              BSR_LEN  = 16,
  parameter int              TST_LEN  = 8,
  parameter int              KEY_LEN  = 12,
  parameter logic [IR_W-1:0] OP_BSR   = 5'h01,
  parameter logic [IR_W-1:0] OP_TST   = 5'h1C,
  parameter logic [IR_W-1:0] OP_KEY   = 5'h1A,
  parameter logic [IR_W-1:0] OP_HIGHZ = 5'h08
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  logic [3:0]         tap_state,
  input  logic [IR_W-1:0]    ir_code,
  input  logic               priv_en,
  input  logic               core_tdo,
  input  logic [BSR_LEN-1:0] bsr_cap,
  input  logic [TST_LEN-1:0] tst_cap,
  input  logic [KEY_LEN-1:0] key_cap,
  output logic               tdo,
  output logic               pins_hiz,
  output logic [BSR_LEN-1:0] bsr_upd,
  output logic [TST_LEN-1:0] tst_upd,
  output logic [KEY_LEN-1:0] key_upd
);

  tap_st_e st;
  path_e   path;
  logic    in_cap, in_shf, in_upd;
  logic    bsr_lsb, tst_lsb, key_lsb;
  logic    byp_q;
  logic    local_bit;
  logic    shift_own;

  assign st     = tap_st_e'(tap_state);
  assign in_cap = (st == ST_CAPTURE_DR);
  assign in_shf = (st == ST_SHIFT_DR);
  assign in_upd = (st == ST_UPDATE_DR);

  jtu_decode #(
    .IR_W(IR_W), .OP_BSR(OP_BSR), .OP_TST(OP_TST),
    .OP_KEY(OP_KEY), .OP_HIGHZ(OP_HIGHZ)
  ) u_decode (
    .ir_code (ir_code),
    .priv_en (priv_en),
    .path    (path)
  );

  jtu_dreg #(.LEN(BSR_LEN)) u_bsr (
    .tck(tck), .trst_n(trst_n), .sel(path == PATH_BSR),
    .cap_en(in_cap), .shf_en(in_shf), .upd_en(in_upd), .tdi(tdi),
    .cap_val(bsr_cap), .sr_lsb(bsr_lsb), .upd_q(bsr_upd)
  );

  jtu_dreg #(.LEN(TST_LEN)) u_tst (
    .tck(tck), .trst_n(trst_n), .sel(path == PATH_TST),
    .cap_en(in_cap), .shf_en(in_shf), .upd_en(in_upd), .tdi(tdi),
    .cap_val(tst_cap), .sr_lsb(tst_lsb), .upd_q(tst_upd)
  );

  jtu_dreg #(.LEN(KEY_LEN)) u_key (
    .tck(tck), .trst_n(trst_n), .sel(path == PATH_KEY),
    .cap_en(in_cap), .shf_en(in_shf), .upd_en(in_upd), .tdi(tdi),
    .cap_val(key_cap), .sr_lsb(key_lsb), .upd_q(key_upd)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (path == PATH_BYP) begin
      if (in_cap)      byp_q <= 1'b0;
      else if (in_shf) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) pins_hiz <= 1'b0;
    else         pins_hiz <= (path == PATH_BYP);
  end

  always_comb begin
    case (path)
      PATH_BSR: local_bit = bsr_lsb;
      PATH_TST: local_bit = tst_lsb;
      PATH_KEY: local_bit = key_lsb;
      PATH_BYP: local_bit = byp_q;
      default:  local_bit = 1'b0;
    endcase
  end

  assign shift_own = (path != PATH_CORE) && in_shf;

  jtu_tdo_out u_tdo (
    .tck       (tck),
    .trst_n    (trst_n),
    .shift_own (shift_own),
    .local_bit (local_bit),
    .core_tdo  (core_tdo),
    .tdo       (tdo)
  );

  // R6
  priv_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!priv_en) |-> (path != PATH_TST && path != PATH_KEY));

  // R7
  hiz_follow_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_code == OP_HIGHZ) |=> pins_hiz);

endmodule

// File: tb/jtag_test_follower_tb.sv
module jtag_test_follower_tb;

  localparam int TCK_PERIOD = 20;
  localparam int IR_W = 5;
  localparam int BL = 16;
  localparam int TL = 8;
  localparam int KL = 12;
  localparam logic [IR_W-1:0] OP_BSR   = 5'h01;
  localparam logic [IR_W-1:0] OP_TST   = 5'h1C;
  localparam logic [IR_W-1:0] OP_KEY   = 5'h1A;
  localparam logic [IR_W-1:0] OP_HIGHZ = 5'h08;
  localparam logic [IR_W-1:0] OP_OTHER = 5'h1F;

  logic            tck = 1'b0;
  logic            trst_n = 1'b0;
  logic            tdi = 1'b0;
  logic [3:0]      tap_state = 4'hF;
  logic [IR_W-1:0] ir_code = '0;
  logic            priv_en = 1'b0;
  logic            core_tdo = 1'b0;
  logic [BL-1:0]   bsr_cap = 16'hA5C3;
  logic [TL-1:0]   tst_cap = 8'h5E;
  logic [KL-1:0]   key_cap = 12'h9B4;
  logic            tdo, pins_hiz;
  logic [BL-1:0]   bsr_upd;
  logic [TL-1:0]   tst_upd;
  logic [KL-1:0]   key_upd;

  jtag_test_follower u_dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tap_state(tap_state),
    .ir_code(ir_code), .priv_en(priv_en), .core_tdo(core_tdo),
    .bsr_cap(bsr_cap), .tst_cap(tst_cap), .key_cap(key_cap),
    .tdo(tdo), .pins_hiz(pins_hiz), .bsr_upd(bsr_upd),
    .tst_upd(tst_upd), .key_upd(key_upd)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] m_sr [3];
  logic [63:0] m_up [3];
  int          m_len [3] = '{BL, TL, KL};
  logic        m_byp, m_hiz, m_fresh;
  logic [IR_W-1:0] nxt_ir = '0;
  logic        nxt_priv = 1'b0;
  logic        last_own = 1'b0;
  logic        last_exp = 1'b0;

  function automatic int path_of(logic [IR_W-1:0] ir, logic pv);
    if (ir == OP_BSR)         return 1;
    if (ir == OP_HIGHZ)       return 4;
    if (pv && ir == OP_TST)   return 2;
    if (pv && ir == OP_KEY)   return 3;
    return 0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin
      m_sr[i] = '0;
      m_up[i] = '0;
    end
    m_byp = 0; m_hiz = 0; m_fresh = 0; last_own = 0;
  endtask

  task automatic step(logic [3:0] st, logic d);
    int p;
    logic exp_tdo;
    string tg;
    @(posedge tck); #1;
    // R4: a rising edge must not move a locally driven tdo
    if (last_own) chk("R4", tdo, last_exp);
    tap_state = st; tdi = d; core_tdo = ~core_tdo;
    ir_code = nxt_ir; priv_en = nxt_priv;
    @(negedge tck); #2;
    p = path_of(ir_code, priv_en);
    if (p != 0 && st == 4'h2) begin
      exp_tdo = (p == 4) ? m_byp : m_sr[p-1][0];
      tg = (p == 4) ? "R7" : (m_fresh ? "R2" : "R3");
    end else begin
      exp_tdo = core_tdo;
      tg = (ir_code == OP_TST || ir_code == OP_KEY) ? "R6" : "R1";
    end
    chk(tg, tdo, exp_tdo);
    last_own = (p != 0 && st == 4'h2);
    last_exp = exp_tdo;
    chk("R7", pins_hiz, m_hiz);
    chk(p == 1 ? "R5" : "R9", bsr_upd, m_up[0][BL-1:0]);
    chk(p == 2 ? "R5" : "R9", tst_upd, m_up[1][TL-1:0]);
    chk(p == 3 ? "R5" : "R9", key_upd, m_up[2][KL-1:0]);
    // effect of the rising edge that ends this state
    if (p >= 1 && p <= 3) begin
      if (st == 4'h6) begin
        m_sr[p-1] = (p == 1) ? 64'(bsr_cap) : (p == 2) ? 64'(tst_cap) : 64'(key_cap);
        m_fresh = 1;
      end else if (st == 4'h2) begin
        m_sr[p-1] = (m_sr[p-1] >> 1) | (64'(d) << (m_len[p-1] - 1));
        m_fresh = 0;
      end else if (st == 4'h5) begin
        m_up[p-1] = m_sr[p-1];
      end
    end else if (p == 4) begin
      if (st == 4'h6)      m_byp = 0;
      else if (st == 4'h2) m_byp = d;
    end
    m_hiz = (p == 4);
  endtask

  task automatic scan(logic [63:0] pat, int n, bit with_pause);
    step(4'hC, 0);
    step(4'h7, 0);
    step(4'h6, 0);
    for (int i = 0; i < n; i++) begin
      step(4'h2, pat[i]);
      if (with_pause && i == n/2) begin
        step(4'h1, 0);
        step(4'h3, 0);
        step(4'h3, 0);
        step(4'h0, 0);
      end
    end
    step(4'h1, 0);
    step(4'h5, 0);
    step(4'hC, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(TCK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge tck);
    #3; tap_state = 4'hC; trst_n = 1'b1;
    #1;
    // R8: state after reset release
    chk("R8", tdo, core_tdo);
    chk("R8", pins_hiz, 0);
    chk("R8", {bsr_upd, tst_upd, key_upd}, 0);

    // boundary scan, LSB first shifting with a pause in the middle
    nxt_ir = OP_BSR; nxt_priv = 0;
    scan(64'h0000_0000_0000_3C69, BL, 1);
    chk("R5", bsr_upd, 16'h3C69);

    // restricted opcodes while disabled
    nxt_ir = OP_TST; scan(64'hFF, TL, 0);
    chk("R6", tst_upd, 0);
    nxt_ir = OP_KEY; scan(64'hFFF, KL, 0);
    chk("R6", key_upd, 0);

    // restricted opcodes while enabled
    nxt_priv = 1;
    nxt_ir = OP_TST; scan(64'hC3, TL, 0);
    chk("R5", tst_upd, 8'hC3);
    tst_cap = 8'h81; key_cap = 12'h7E1;
    nxt_ir = OP_KEY; scan(64'h2D6, KL, 1);
    chk("R5", key_upd, 12'h2D6);
    chk("R9", bsr_upd, 16'h3C69);

    // foreign opcode
    nxt_ir = OP_OTHER; scan(64'h5555, BL, 0);
    chk("R1", {bsr_upd, tst_upd, key_upd}, {16'h3C69, 8'hC3, 12'h2D6});

    // HIGH_Z with bypass
    nxt_ir = OP_HIGHZ; scan(64'hB2, 8, 0);
    chk("R7", pins_hiz, 1);

    // partial shift, then asynchronous reset
    nxt_ir = OP_BSR;
    step(4'hC, 0); step(4'h7, 0); step(4'h6, 0);
    step(4'h2, 1); step(4'h2, 0);
    @(negedge tck); #4;
    trst_n = 1'b0;
    #1;
    chk("R8", {bsr_upd, tst_upd, key_upd}, 0);
    chk("R8", pins_hiz, 0);
    chk("R8", tdo, core_tdo);
    model_clear();
    @(posedge tck); #3;
    tap_state = 4'hC; trst_n = 1'b1;
    scan(64'h0000_0000_0000_F00D, BL, 0);
    chk("R5", bsr_upd, 16'hF00D);

    done = 1;
    summary();
    $finish;
  end

endmodule